// File: doc/BRIEF.md
# Multi-source interrupt request controller

This block gathers interrupt events for a small 4-bit microcontroller core. It watches twelve level-sensitive external pins (three groups of four), one external pin whose edge sensitivity is configurable, six time base tap pulses and two melody-completion pulses. Two of the time base taps only count as sources while a test-mode input is high. In normal mode, four taps are live.

Every source has its own enable bit and a pending flag. An enabled event sets the flag. The flag stays set until the CPU acknowledges that source by its index. A master enable gates the request line. The lowest-numbered pending source is offered to the CPU as the source index. The source numbering is fixed: index 0–11 is level pin 0–11, index 12 is the edge pin, index 13+k is time base tap k (k = 0..5), and index 19+m is melody channel m (m = 0..1). Enable bit i belongs to source index i.

Top module: `irq_collector`

## Requirements
- R1: After reset all pending flags, all enables, the master enable and the edge mode are zero. `irq_req` is low and `irq_idx` is 0.
- R2: A level pin i that is high while enable bit i is set marks source i pending. The flag appears in the third clock edge after the pin is driven, because two synchroniser stages sit in front of it.
- R3: A pending level source whose pin is still high stays pending after an acknowledge of its index. Once the pin is low, an acknowledge clears it.
- R4: The edge pin (index 12) uses a two-bit mode: 00 ignores the pin, 01 fires on a rising edge, 10 fires on a falling edge, and 11 fires on both edges. Edges are taken after the two-stage synchroniser.
- R5: A one-cycle pulse on time base tap k (k = 0..3) marks index 13+k pending on the next clock edge.
- R6: Taps 4 and 5 (indices 17 and 18) set a pending flag only while `test_mode` is high. With `test_mode` low their pulses are ignored.
- R7: A one-cycle pulse on melody channel m marks index 19+m pending on the next clock edge.
- R8: An event on a source whose enable bit is clear leaves no pending flag. Setting the enable later does not recover the lost event.
- R9: `irq_req` is high only when the master enable is set and at least one flag is pending. Pending flags are kept while the master enable is low.
- R10: When several flags are pending, `irq_idx` shows the lowest pending index.
- R11: An acknowledge clears only the flag whose index it carries. Every other pending flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_pin | input | 12 | Level-sensitive external pins, sources 0–11 |
| edge_pin | input | 1 | Edge-selectable external pin, source 12 |
| tb_tick | input | 6 | Time base tap pulses, sources 13–18 |
| mel_done | input | 2 | Melody completion pulses, sources 19–20 |
| test_mode | input | 1 | Makes taps 4 and 5 valid sources |
| cfg_we | input | 1 | Loads enables, master enable and edge mode |
| cfg_en | input | 21 | Per-source enables, bit i for source i |
| cfg_mie | input | 1 | Master interrupt enable |
| cfg_edge_mode | input | 2 | Edge pin mode (00 off, 01 rise, 10 fall, 11 both) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 5 | Index of the source being acknowledged |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 5 | Lowest pending source index |

## Verification
The bench holds a level pin high across an acknowledge. A design that treated level sources as one-shot would drop the request while the pin is still asserted. Each of the four edge modes is driven in both directions, which shows up a swapped or missing polarity bit. The two test-only taps are pulsed with `test_mode` low and then high, to catch a design that counts six taps all the time. Simultaneous tap and melody events, together with an acknowledge of a non-pending index, expose a reversed priority or an acknowledge that clears too much.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int N_LVL  = 12,
  parameter int N_TB   = 6,
  parameter int N_TBX  = 2,
  parameter int N_MEL  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N_LVL-1:0]                      lvl_pin,
  input  logic                                  edge_pin,
  input  logic [N_TB-1:0]                       tb_tick,
  input  logic [N_MEL-1:0]                      mel_done,
  input  logic                                  test_mode,
  input  logic                                  cfg_we,
  input  logic [N_LVL+1+N_TB+N_MEL-1:0]         cfg_en,
  input  logic                                  cfg_mie,
  input  logic [1:0]                            cfg_edge_mode,
  input  logic                                  ack_valid,
  input  logic [$clog2(N_LVL+1+N_TB+N_MEL)-1:0] ack_idx,
  output logic                                  irq_req,
  output logic [$clog2(N_LVL+1+N_TB+N_MEL)-1:0] irq_idx
);
  localparam int NSRC   = N_LVL + 1 + N_TB + N_MEL;
  localparam int IW     = $clog2(NSRC);
  localparam int I_EDGE = N_LVL;
  localparam int I_TB   = N_LVL + 1;
  localparam int I_TBX  = I_TB + N_TB - N_TBX;
  localparam logic [N_TB-1:0] TB_BASE = N_TB'((1 << (N_TB - N_TBX)) - 1);

  logic [N_LVL-1:0] lvl_s1, lvl_s2;
  logic [2:0]       eg;
  logic [NSRC-1:0]  en, pend, evt, set, clr;
  logic [1:0]       mode;
  logic             mie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_s1 <= '0;
      lvl_s2 <= '0;
      eg     <= '0;
    end else begin
      lvl_s1 <= lvl_pin;
      lvl_s2 <= lvl_s1;
      eg     <= {eg[1:0], edge_pin};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en   <= '0;
      mie  <= 1'b0;
      mode <= 2'b00;
    end else if (cfg_we) begin
      en   <= cfg_en;
      mie  <= cfg_mie;
      mode <= cfg_edge_mode;
    end

  wire edge_hit = (mode[0] & eg[1] & ~eg[2]) | (mode[1] & ~eg[1] & eg[2]);
  wire [N_TB-1:0] tb_ok = tb_tick & (test_mode ? {N_TB{1'b1}} : TB_BASE);

  assign evt = {mel_done, tb_ok, edge_hit, lvl_s2};
  assign set = evt & en;
  assign clr = ack_valid ? (NSRC'(1) << ack_idx) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | set;

  always_comb begin
    irq_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) irq_idx = IW'(i);
  end

  assign irq_req = mie & (|pend);

  // R8
  new_pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(en)) == '0);
  // R9
  req_needs_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> mie);
  // R10
  idx_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_idx]);
  // R6
  tbx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(test_mode) |-> !$rose(pend[I_TBX]) && !$rose(pend[I_TBX+1]));
  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !set[ack_idx] && int'(ack_idx) < NSRC) |=> !pend[$past(ack_idx)]);
  // R4
  edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00 && !$past(pend[I_EDGE])) |-> !pend[I_EDGE]);
endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
  logic        clk = 0, rst_n = 0;
  logic [11:0] lvl_pin = '0;
  logic        edge_pin = 0;
  logic [5:0]  tb_tick = '0;
  logic [1:0]  mel_done = '0;
  logic        test_mode = 0, cfg_we = 0, cfg_mie = 0, ack_valid = 0;
  logic [20:0] cfg_en = '0;
  logic [1:0]  cfg_edge_mode = '0;
  logic [4:0]  ack_idx = '0;
  logic        irq_req;
  logic [4:0]  irq_idx;
  int tests = 0, fails = 0;
  localparam logic [20:0] ALL = '1;

  irq_collector i_irq_collector (.*);

  always #4 clk = ~clk;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit exp_req, input logic [4:0] exp_idx, input string r);
    tests++;
    if (irq_req !== exp_req || (exp_req && irq_idx !== exp_idx)) begin
      fails++;
      $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d", r, irq_req, irq_idx, exp_req, exp_idx);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [20:0] en, input bit mie, input logic [1:0] md);
    cfg_en = en; cfg_mie = mie; cfg_edge_mode = md; cfg_we = 1;
    cyc(1); cfg_we = 0;
  endtask

  task automatic ack(input logic [4:0] idx);
    ack_idx = idx; ack_valid = 1;
    cyc(1); ack_valid = 0;
  endtask

  task automatic pulse_tb(input int k);
    tb_tick[k] = 1; cyc(1); tb_tick[k] = 0;
  endtask

  task automatic t_reset;
    chk(0, 0, "R1 reset");
    tests++;
    if (irq_idx !== 0) begin fails++; $display("FAIL R1: idx=%0d expected 0", irq_idx); end
    cfg('0, 1, 2'b00); cyc(2);
    chk(0, 0, "R1 nothing pending after reset");
  endtask

  task automatic t_level;
    cfg(ALL, 1, 2'b00);
    lvl_pin[5] = 1; cyc(2);
    chk(0, 0, "R2 not yet through synchroniser");
    cyc(1);
    chk(1, 5, "R2 level pin 5");
    ack(5);
    chk(1, 5, "R3 held while pin high");
    lvl_pin[5] = 0; cyc(3);
    ack(5);
    chk(0, 0, "R3 cleared once pin low");
  endtask

  task automatic t_edge;
    cfg(ALL, 1, 2'b00);
    edge_pin = 1; cyc(4); edge_pin = 0; cyc(4);
    chk(0, 0, "R4 mode 00 ignores pin");
    cfg(ALL, 1, 2'b01);
    edge_pin = 1; cyc(3);
    chk(1, 12, "R4 rising edge");
    ack(12);
    edge_pin = 0; cyc(4);
    chk(0, 0, "R4 rise mode ignores fall");
    cfg(ALL, 1, 2'b10);
    edge_pin = 1; cyc(4);
    chk(0, 0, "R4 fall mode ignores rise");
    edge_pin = 0; cyc(3);
    chk(1, 12, "R4 falling edge");
    ack(12);
    cfg(ALL, 1, 2'b11);
    edge_pin = 1; cyc(3);
    chk(1, 12, "R4 both: rise");
    ack(12);
    edge_pin = 0; cyc(3);
    chk(1, 12, "R4 both: fall");
    ack(12);
    chk(0, 0, "R4 cleared");
    cfg(ALL, 1, 2'b00);
  endtask

  task automatic t_tb_mel;
    for (int k = 0; k < 4; k++) begin
      pulse_tb(k);
      chk(1, 5'(13 + k), "R5 time base tap");
      ack(5'(13 + k));
    end
    for (int m = 0; m < 2; m++) begin
      mel_done[m] = 1; cyc(1); mel_done[m] = 0;
      chk(1, 5'(19 + m), "R7 melody done");
      ack(5'(19 + m));
    end
    chk(0, 0, "R7 all cleared");
  endtask

  task automatic t_testmode;
    test_mode = 0;
    pulse_tb(4); pulse_tb(5); cyc(1);
    chk(0, 0, "R6 taps 4,5 ignored in normal mode");
    test_mode = 1;
    pulse_tb(5);
    chk(1, 18, "R6 tap 5 in test mode");
    pulse_tb(4);
    chk(1, 17, "R6 tap 4 in test mode");
    ack(17); ack(18);
    test_mode = 0;
    chk(0, 0, "R6 cleared");
  endtask

  task automatic t_enable;
    cfg(21'(1) << 19, 1, 2'b00);
    mel_done[1] = 1; cyc(1); mel_done[1] = 0;
    chk(0, 0, "R8 disabled source ignored");
    cfg(ALL, 1, 2'b00); cyc(1);
    chk(0, 0, "R8 lost event not recovered");
  endtask

  task automatic t_master;
    cfg(ALL, 0, 2'b00);
    pulse_tb(0);
    chk(0, 0, "R9 master enable off");
    cfg(ALL, 1, 2'b00);
    chk(1, 13, "R9 pending kept while masked");
    ack(13);
  endtask

  task automatic t_priority;
    tb_tick[1] = 1; mel_done[1] = 1; cyc(1); tb_tick[1] = 0; mel_done[1] = 0;
    chk(1, 14, "R10 lowest index wins");
    ack(15);
    chk(1, 14, "R11 ack of other index leaves flag");
    ack(14);
    chk(1, 20, "R11 only acked flag cleared");
    ack(20);
    chk(0, 0, "R11 all cleared");
  endtask

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    t_reset;
    t_level;
    t_edge;
    t_tb_mel;
    t_testmode;
    t_enable;
    t_master;
    t_priority;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule